// File: doc/BRIEF.md
# March Test Sequencer for Single-Port SRAM

This block is a built-in self-test controller for one single-port synchronous SRAM. A pulse on `start` picks one of three March algorithms through `algSel`, and optionally adds a data-retention tail through `retEn`. The block then walks the whole address space element by element. It issues one write or one read per cycle and compares every read against the background value that the algorithm expects. It needs no software. The surrounding logic only muxes the memory pins over to this block while `busy` is high.

Every write drives either all zeros or all ones across the word. A read is compared against the matching replicated value one cycle after it is issued, so the check runs in step with the next operation. The first mismatch records where it happened: the address, the element index, the operation index inside the element, and whether the expected value was 0 or 1. Any later mismatch only sets a sticky flag. `done` pulses once when the run is over, and the result stays on the outputs until the next accepted start.

Elements are numbered from 0 in the order they run. Direction "up" walks address 0 to the top; "down" walks from the top address to 0. Inside an element, every operation is applied to one address before the walk moves to the next address. N is 2^ADDR_W. H is HOLD_CYCLES.

Top module: `marchBist`

## Requirements
- R1: With algSel = 0 or 3, the run is March C- with 10N operations: e0 up (w0); e1 up (r0,w1); e2 up (r1,w0); e3 down (r0,w1); e4 down (r1,w0); e5 up (r0).
- R2: With algSel = 1, the run is the stuck-open variant with 11N operations. It matches R1 except that e1 is up (r0,w1,r1).
- R3: With algSel = 2, the run is the extended CL variant with 13N operations: e0 up (w0); e1 up (r0,w1,r1); e2 up (r1,w0); e3 up (r0); e4 down (r0,w1); e5 up (r1); e6 down (r1,w0); e7 up (r0).
- R4: With retEn = 1 at start, the base elements are followed by a tail. The tail is a wait of exactly H cycles with memWe and memRe both low, then up (r0,w1), then a second wait of H cycles, then up (r1). The four tail entries take the element indices that follow the last base element.
- R5: Outside the waits, exactly one operation is issued in every cycle from the cycle after the start edge up to the last operation. memWe and memRe are never high together, and both stay low while busy is low. A write drives memWdata as its data bit copied to all DATA_W bits.
- R6: Each read is compared one cycle later against its expected bit copied to all bits. fail is 1 at done if and only if at least one read mismatched.
- R7: The first mismatch of a run sets failAddr, failElem and failOp (the operation position from 0 inside the element). It also sets failStuckHigh, which is 1 when the expected value was 0 (a stuck-at-1 suspect) and 0 when it was 1. These outputs then hold until the next accepted start.
- R8: multiFail becomes 1 when a second or later mismatch happens in the same run, and it stays 1 until the next accepted start.
- R9: busy is 1 from the cycle after the accepted start edge. done is high for exactly one cycle, with busy low, and appears ops + 1 cycles after the start edge, plus 2H cycles when the tail runs.
- R10: A start while busy is 1 is ignored, including any change on algSel and retEn. An accepted start clears fail, multiFail and the captured fields.
- R11: After reset, busy, done, fail, multiFail, memWe and memRe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, taken only while idle |
| algSel | input | 2 | Algorithm: 0/3 March C-, 1 stuck-open variant, 2 extended CL |
| retEn | input | 1 | Add the data-retention tail |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable; data is returned on the next cycle |
| memRdata | input | DATA_W | Memory read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | At least one read mismatched |
| multiFail | output | 1 | More than one read mismatched |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failElem | output | 4 | Element index of the first mismatch |
| failOp | output | 2 | Operation index of the first mismatch |
| failStuckHigh | output | 1 | The first mismatch expected 0 |

## Verification
The scoreboard rebuilds the full operation stream of each algorithm, with and without the tail, and compares address, direction, data and the idle gap at every element boundary. A design that ran an element in the wrong direction, dropped the extra r1, or stretched a wait by one cycle would show a stream mismatch or a wrong done time. Stuck cells are placed so that the first failing read lands on a known element and operation: operation 0 of e1, the final r1 of the extended e1, and the last address of an ascending e2. A capture that kept the last mismatch instead of the first, or that swapped the stuck polarity, would report the wrong fields. A cell flipped during the first wait must be caught by operation 0 of the first tail element with multiFail still 0. That check exposes both a wait that toggles the enables and a multi-fail flag that counts the first error. A start issued in the middle of a run with different settings must leave the stream and the timing unchanged, and a clean run after faulty ones must come back with all failure outputs cleared.

// File: rtl/marchBistPkg.sv
package marchBistPkg;

  localparam int ELEM_W = 4;
  localparam int OP_W   = 2;

  typedef enum logic [1:0] {
    ALG_CMINUS   = 2'd0,
    ALG_CMINUS_X = 2'd1,
    ALG_CL_X     = 2'd2,
    ALG_ALIAS    = 2'd3
  } alg_e;

  // One element descriptor: operation k is a write when wrMask[k] is 1, and uses valMask[k] as its data bit.
  typedef struct packed {
    logic       isWait;
    logic       down;
    logic [1:0] nOps;
    logic [2:0] wrMask;
    logic [2:0] valMask;
    logic       last;
  } elem_t;

  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic              clr;
    logic              wr;
    logic              rd;
    logic              dataBit;
    logic [ELEM_W-1:0] elem;
    logic [OP_W-1:0]   op;
  } strobe_t;

  function automatic elem_t mkElem(input logic dn, input logic [1:0] n,
                                   input logic [2:0] wr, input logic [2:0] val);
    elem_t e;
    e.isWait  = 1'b0;
    e.down    = dn;
    e.nOps    = n;
    e.wrMask  = wr;
    e.valMask = val;
    e.last    = 1'b0;
    return e;
  endfunction

  function automatic logic [ELEM_W-1:0] baseLen(input alg_e alg);
    return (alg == ALG_CL_X) ? 4'd8 : 4'd6;
  endfunction

  function automatic elem_t elemRom(input alg_e alg, input logic ret, input logic [ELEM_W-1:0] idx);
    elem_t e;
    logic [ELEM_W-1:0] bl;
    logic [ELEM_W-1:0] t;
    bl = baseLen(alg);
    t  = idx - bl;
    e  = mkElem(1'b0, 2'd1, 3'b001, 3'b000);
    if (idx < bl) begin
      if (alg == ALG_CL_X) begin
        case (idx)
          4'd1:    e = mkElem(1'b0, 2'd3, 3'b010, 3'b110);
          4'd2:    e = mkElem(1'b0, 2'd2, 3'b010, 3'b001);
          4'd3:    e = mkElem(1'b0, 2'd1, 3'b000, 3'b000);
          4'd4:    e = mkElem(1'b1, 2'd2, 3'b010, 3'b010);
          4'd5:    e = mkElem(1'b0, 2'd1, 3'b000, 3'b001);
          4'd6:    e = mkElem(1'b1, 2'd2, 3'b010, 3'b001);
          4'd7:    e = mkElem(1'b0, 2'd1, 3'b000, 3'b000);
          default: e = mkElem(1'b0, 2'd1, 3'b001, 3'b000);
        endcase
      end else begin
        case (idx)
          4'd1:    e = (alg == ALG_CMINUS_X) ? mkElem(1'b0, 2'd3, 3'b010, 3'b110)
                                             : mkElem(1'b0, 2'd2, 3'b010, 3'b010);
          4'd2:    e = mkElem(1'b0, 2'd2, 3'b010, 3'b001);
          4'd3:    e = mkElem(1'b1, 2'd2, 3'b010, 3'b010);
          4'd4:    e = mkElem(1'b1, 2'd2, 3'b010, 3'b001);
          4'd5:    e = mkElem(1'b0, 2'd1, 3'b000, 3'b000);
          default: e = mkElem(1'b0, 2'd1, 3'b001, 3'b000);
        endcase
      end
      e.last = !ret && (idx == bl - 4'd1);
    end else begin
      case (t)
        4'd0, 4'd2: begin
          e        = '0;
          e.isWait = 1'b1;
        end
        4'd1:    e = mkElem(1'b0, 2'd2, 3'b010, 3'b010);
        default: begin
          e      = mkElem(1'b0, 2'd1, 3'b000, 3'b001);
          e.last = 1'b1;
        end
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/marchBistCtrl.sv
module marchBistCtrl
  import marchBistPkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int HOLD_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        algSel,
  input  logic              retEn,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done
);

  localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [ADDR_W-1:0] STEP_LAST = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_e;

  state_e            state;
  alg_e              alg;
  logic              ret;
  logic [ELEM_W-1:0] elemIdx;
  logic [OP_W-1:0]   opIdx;
  logic [ADDR_W-1:0] stepQ;
  logic [HOLD_W-1:0] waitCnt;
  logic              doneQ;

  elem_t cur;
  logic  opLast, stepEnd, opWr, issue;

  always_comb begin
    cur     = elemRom(alg, ret, elemIdx);
    opLast  = (opIdx == cur.nOps - 2'd1);
    stepEnd = (stepQ == STEP_LAST);
    opWr    = cur.wrMask[opIdx];
    issue   = (state == ST_RUN) && !cur.isWait;
  end

  // A descending walk is the bitwise mirror of the ascending step count.
  assign addr = cur.down ? ~stepQ : stepQ;

  always_comb begin
    stb.clr     = (state == ST_IDLE) && start;
    stb.wr      = issue && opWr;
    stb.rd      = issue && !opWr;
    stb.dataBit = cur.valMask[opIdx];
    stb.elem    = elemIdx;
    stb.op      = opIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      alg     <= ALG_CMINUS;
      ret     <= 1'b0;
      elemIdx <= '0;
      opIdx   <= '0;
      stepQ   <= '0;
      waitCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            alg     <= alg_e'(algSel);
            ret     <= retEn;
            elemIdx <= '0;
            opIdx   <= '0;
            stepQ   <= '0;
            waitCnt <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cur.isWait) begin
            if (waitCnt == HOLD_LAST) begin
              waitCnt <= '0;
              elemIdx <= elemIdx + 4'd1;
            end else begin
              waitCnt <= waitCnt + 1'b1;
            end
          end else if (!opLast) begin
            opIdx <= opIdx + 2'd1;
          end else begin
            opIdx <= '0;
            if (!stepEnd) begin
              stepQ <= stepQ + 1'b1;
            end else begin
              stepQ <= '0;
              if (cur.last) state <= ST_DRAIN;
              else          elemIdx <= elemIdx + 4'd1;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/marchBistDp.sv
module marchBistDp
  import marchBistPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              fail,
  output logic              multiFail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [ELEM_W-1:0] failElem,
  output logic [OP_W-1:0]   failOp,
  output logic              failStuckHigh
);

  assign memAddr  = addrIn;
  assign memWe    = stb.wr;
  assign memRe    = stb.rd;
  assign memWdata = {DATA_W{stb.dataBit}};

  // Context of the read in flight, compared in the next cycle.
  logic              pendV;
  logic              pendExp;
  logic [ADDR_W-1:0] pendAddr;
  logic [ELEM_W-1:0] pendElem;
  logic [OP_W-1:0]   pendOp;
  logic              mismatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendV    <= 1'b0;
      pendExp  <= 1'b0;
      pendAddr <= '0;
      pendElem <= '0;
      pendOp   <= '0;
    end else begin
      pendV <= stb.rd;
      if (stb.rd) begin
        pendExp  <= stb.dataBit;
        pendAddr <= addrIn;
        pendElem <= stb.elem;
        pendOp   <= stb.op;
      end
    end
  end

  assign mismatch = pendV && (memRdata != {DATA_W{pendExp}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail          <= 1'b0;
      multiFail     <= 1'b0;
      failAddr      <= '0;
      failElem      <= '0;
      failOp        <= '0;
      failStuckHigh <= 1'b0;
    end else if (stb.clr) begin
      fail          <= 1'b0;
      multiFail     <= 1'b0;
      failAddr      <= '0;
      failElem      <= '0;
      failOp        <= '0;
      failStuckHigh <= 1'b0;
    end else if (mismatch) begin
      if (!fail) begin
        fail          <= 1'b1;
        failAddr      <= pendAddr;
        failElem      <= pendElem;
        failOp        <= pendOp;
        failStuckHigh <= !pendExp;
      end else begin
        multiFail <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/marchBist.sv
module marchBist
  import marchBistPkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        algSel,
  input  logic              retEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              multiFail,
  output logic [ADDR_W-1:0] failAddr,
  output logic [3:0]        failElem,
  output logic [1:0]        failOp,
  output logic              failStuckHigh
);

  strobe_t           stb;
  logic [ADDR_W-1:0] ctlAddr;

  marchBistCtrl #(.ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .algSel(algSel), .retEn(retEn),
    .stb(stb), .addr(ctlAddr), .busy(busy), .done(done)
  );

  marchBistDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addrIn(ctlAddr),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .fail(fail), .multiFail(multiFail),
    .failAddr(failAddr), .failElem(failElem), .failOp(failOp),
    .failStuckHigh(failStuckHigh)
  );

endmodule

// File: rtl/marchBistChk.sv
module marchBistChk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memWe,
  input logic              memRe,
  input logic              fail,
  input logic              multiFail,
  input logic [ADDR_W-1:0] failAddr,
  input logic [3:0]        failElem,
  input logic [1:0]        failOp
);

  a_r5_exclusive_enables: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r8_multi_needs_fail: assert property (@(posedge clk) disable iff (!rstN)
    multiFail |-> fail);

  a_r7_capture_stable: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !(start && !busy)) |=> ($stable(failAddr) && $stable(failElem) && $stable(failOp) && fail));

  a_r6_fail_rises_in_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> $past(busy));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> (busy || done));

endmodule

bind marchBist marchBistChk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .memWe(memWe), .memRe(memRe), .fail(fail), .multiFail(multiFail),
  .failAddr(failAddr), .failElem(failElem), .failOp(failOp)
);

// File: tb/marchBist_test.sv
module marchBist_test;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int HOLD   = 20;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] algSel = 2'd0;
  logic retEn = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic memWe, memRe;
  logic [DATA_W-1:0] memRdata;
  logic busy, done, fail, multiFail, failStuckHigh;
  logic [ADDR_W-1:0] failAddr;
  logic [3:0] failElem;
  logic [1:0] failOp;

  always #4 clk = ~clk;

  marchBist #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rstN(rstN), .start(start), .algSel(algSel), .retEn(retEn),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .busy(busy), .done(done), .fail(fail),
    .multiFail(multiFail), .failAddr(failAddr), .failElem(failElem),
    .failOp(failOp), .failStuckHigh(failStuckHigh)
  );

  // Memory model with one injectable stuck fault and one retention flip.
  logic [DATA_W-1:0] mem [DEPTH];
  int faultAddr = -1;
  logic [DATA_W-1:0] faultMask = '0;
  logic [DATA_W-1:0] faultVal = '0;
  logic corruptReq = 1'b0;
  int corruptAddr = 7;

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (corruptReq) mem[corruptAddr] <= mem[corruptAddr] ^ 8'h01;
    if (memRe) begin
      if (int'(memAddr) == faultAddr)
        memRdata <= (mem[memAddr] & ~faultMask) | (faultVal & faultMask);
      else
        memRdata <= mem[memAddr];
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct { bit we; int addr; bit val; int gap; } op_t;
  op_t expQ[$];
  int idleCnt = 0;
  int opsSeen = 0;
  int streamErr = 0;
  bit monOn = 0;
  string curReq = "R1";

  task automatic pushElem(bit dn, string ops, int gapFirst);
    int n = ops.len() / 2;
    bit first = 1;
    for (int s = 0; s < DEPTH; s++) begin
      for (int k = 0; k < n; k++) begin
        op_t o;
        o.we   = (ops[2*k] == "w");
        o.val  = (ops[2*k+1] == "1");
        o.addr = dn ? (DEPTH - 1 - s) : s;
        o.gap  = first ? gapFirst : 0;
        first  = 0;
        expQ.push_back(o);
      end
    end
  endtask

  task automatic buildSeq(int alg, bit ret);
    if (alg == 2) begin
      pushElem(0, "w0", -1);   pushElem(0, "r0w1r1", 0); pushElem(0, "r1w0", 0);
      pushElem(0, "r0", 0);    pushElem(1, "r0w1", 0);   pushElem(0, "r1", 0);
      pushElem(1, "r1w0", 0);  pushElem(0, "r0", 0);
    end else begin
      pushElem(0, "w0", -1);
      pushElem(0, (alg == 1) ? "r0w1r1" : "r0w1", 0);
      pushElem(0, "r1w0", 0);  pushElem(1, "r0w1", 0);
      pushElem(1, "r1w0", 0);  pushElem(0, "r0", 0);
    end
    if (ret) begin
      pushElem(0, "r0w1", HOLD);
      pushElem(0, "r1", HOLD);
    end
  endtask

  always @(negedge clk) begin : monitor
    op_t e;
    if (monOn && (memWe || memRe)) begin
      opsSeen++;
      if (expQ.size() == 0) begin
        if (streamErr == 0)
          $display("FAIL %s op stream: actual extra op at addr %0d expected none", curReq, memAddr);
        streamErr++;
      end else begin
        e = expQ.pop_front();
        if (memWe != e.we || int'(memAddr) != e.addr ||
            (e.we && memWdata != {DATA_W{e.val}}) ||
            (e.gap >= 0 && idleCnt != e.gap)) begin
          if (streamErr == 0)
            $display("FAIL %s op %0d: actual we=%0b addr=%0d wdata=%h gap=%0d expected we=%0b addr=%0d val=%0b gap=%0d",
                     curReq, opsSeen, memWe, memAddr, memWdata, idleCnt, e.we, e.addr, e.val, e.gap);
          streamErr++;
        end
      end
      idleCnt = 0;
    end else if (monOn) begin
      idleCnt++;
    end
  end

  task automatic runAlg(int alg, bit ret, string req, int expCycles, int pokeAt, bit doCorrupt);
    int cnt = 0;
    bit corrupted = 0;
    expQ.delete();
    buildSeq(alg, ret);
    curReq = req;
    streamErr = 0; opsSeen = 0; idleCnt = 0; monOn = 1;
    algSel = alg[1:0]; retEn = ret; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    while (!done && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (cnt == pokeAt) begin
        start = 1'b1; algSel = alg[1:0] ^ 2'b01; retEn = !ret;
      end else begin
        start = 1'b0;
      end
      if (doCorrupt && !corrupted && opsSeen == 10 * DEPTH) begin
        corruptReq = 1'b1; corrupted = 1;
      end else begin
        corruptReq = 1'b0;
      end
    end
    start = 1'b0; corruptReq = 1'b0;
    chk(cnt == expCycles, "R9", {req, " cycles start to done"}, cnt, expCycles);
    chk(busy == 1'b0, "R9", "busy low with done", busy, 0);
    chk(streamErr == 0 && expQ.size() == 0, req, "op stream mismatches plus missing ops",
        streamErr + expQ.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", done, 1'b0);
    monOn = 0;
  endtask

  task automatic checkFail(string req, bit f, int a, int el, int op, bit sh, bit m);
    chk(fail == f, "R6", {req, " fail"}, fail, f);
    if (f) begin
      chk(int'(failAddr) == a, "R7", {req, " failAddr"}, failAddr, a);
      chk(int'(failElem) == el, "R7", {req, " failElem"}, failElem, el);
      chk(int'(failOp) == op, "R7", {req, " failOp"}, failOp, op);
      chk(failStuckHigh == sh, "R7", {req, " failStuckHigh"}, failStuckHigh, sh);
    end
    chk(multiFail == m, "R8", {req, " multiFail"}, multiFail, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R11", "busy/done in reset", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0 && multiFail == 0, "R11", "status after reset",
        {busy, done, fail, multiFail}, 0);
    chk(memWe == 0 && memRe == 0, "R11", "enables after reset", {memWe, memRe}, 0);

    // Clean runs of each algorithm
    runAlg(0, 0, "R1", 10 * DEPTH + 1, 0, 0);
    checkFail("R6 clean C-", 0, 0, 0, 0, 0, 0);
    runAlg(1, 0, "R2", 11 * DEPTH + 1, 0, 0);
    checkFail("R6 clean variant", 0, 0, 0, 0, 0, 0);
    runAlg(2, 0, "R3", 13 * DEPTH + 1, 0, 0);
    checkFail("R6 clean CL", 0, 0, 0, 0, 0, 0);
    runAlg(3, 0, "R1", 10 * DEPTH + 1, 0, 0);
    runAlg(0, 1, "R4", 13 * DEPTH + 2 * HOLD + 1, 0, 0);
    checkFail("R4 clean tail", 0, 0, 0, 0, 0, 0);

    // Stuck-at-1 on bit 3 of address 5: first r0 in e1 op 0
    faultAddr = 5; faultMask = 8'h08; faultVal = 8'h08;
    runAlg(0, 0, "R5", 10 * DEPTH + 1, 0, 0);
    checkFail("R7 sa1", 1, 5, 1, 0, 1, 1);

    // Stuck-at-0 on bit 0 of address 9 under CL: the r1 of e1, op 2
    faultAddr = 9; faultMask = 8'h01; faultVal = 8'h00;
    runAlg(2, 0, "R3", 13 * DEPTH + 1, 0, 0);
    checkFail("R7 sa0 CL", 1, 9, 1, 2, 0, 1);

    // Stuck-at-0 on bit 7 of the top address under C-: e2 op 0, last in ascending order
    faultAddr = DEPTH - 1; faultMask = 8'h80; faultVal = 8'h00;
    runAlg(0, 0, "R1", 10 * DEPTH + 1, 0, 0);
    checkFail("R7 sa0 top", 1, DEPTH - 1, 2, 0, 0, 1);

    // Retention flip of address 7 during the first wait: tail element 7, op 0
    faultAddr = -1; faultMask = '0;
    runAlg(0, 1, "R4", 13 * DEPTH + 2 * HOLD + 1, 0, 1);
    checkFail("R4 retention", 1, 7, 7, 0, 1, 0);

    // Clean run with a start in the middle of it: ignored, results cleared
    runAlg(2, 0, "R10", 13 * DEPTH + 1, 50, 0);
    checkFail("R10 cleared", 0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual run still active expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule